// File: doc/BRIEF.md
# Masked Nibble Substitution Layer

This block is the nonlinear layer of a bit-sliced 128-bit cipher round in which every intermediate value travels under a mask. The state arrives as 32 nibbles. Nibble i gathers bit i of each of the four 32-bit state words. Each nibble is already masked and has already passed through the hardwired word rotation that comes before the substitution. Every one of the 32 lanes owns a 16-entry table. Each table removes the lane's input pad, applies the 4-bit substitution and adds the lane's own output pad. The result is a state that is masked only under the fresh output pads.

Every encoding is an XOR with a 4-bit pad, so each bit can be unmasked on its own. The block stores the pads that the preceding layer used on its outputs. Because the word rotations move bits between nibbles, the input pad of a lane is gathered one bit at a time from four different source lanes. A reload strobe installs a new pair of pad sets between encryptions. A reload that arrives while lookups are running is held back until the first idle cycle.

Top module: `masked_sbox_layer`

## Requirements
- R1: After reset, out_valid and out_data are 0 and both pad sets are all zero, so a lookup returns the plain substitution of its input.
- R2: The substitution maps 0..F to 7,A,2,C,4,8,F,0,5,9,1,E,3,D,B,6. Nibble bit 0 is taken from word 0 and bit 3 from word 3.
- R3: Lane i occupies bits [4i+3:4i] of in_data, out_data, rld_src_pad and rld_out_pad.
- R4: Bit k of the input pad of lane i is bit k of the stored source pad of lane (i - r_k) mod 32, with r = 0, 1, 5, 2 for k = 0..3.
- R5: Output lane i equals S(x XOR input pad) XOR output pad i. Removing the output pads therefore gives the substitution of the true state, for any pads.
- R6: out_data and out_valid are registered. out_valid is 1 in exactly the cycle after each cycle with in_valid high.
- R7: While in_valid is low, out_data holds its last value.
- R8: A reload in a cycle with in_valid low is used by lookups from the next cycle on.
- R9: A reload in a cycle with in_valid high is deferred. Lookups keep the old pads until the first cycle with in_valid low, and the new pads apply from the cycle after that.
- R10: When several reloads arrive before a commit, only the most recent set is installed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A masked state is presented for lookup |
| in_data | input | 128 | 32 masked, rotated nibbles |
| rld_valid | input | 1 | Reload strobe for both pad sets |
| rld_src_pad | input | 128 | New pads of the preceding layer's outputs, one per lane |
| rld_out_pad | input | 128 | New output pads, one per lane |
| out_valid | output | 1 | out_data holds a fresh result |
| out_data | output | 128 | 32 nibbles masked under the output pads |

## Verification
The hardest case to reach from the ports is a reload that lands inside a running burst of lookups, or two reloads that pile up before a commit. The bench drives in_valid for several back-to-back cycles while pulsing the reload strobe. It checks that the lookups still inside the burst use the old pads, and that the lookup after the first idle cycle uses only the latest set. The gather rule is exercised with one-hot source pads and with random pads. Each case is checked against a rotation of whole mask words computed in the bench.

// File: rtl/mnl_pkg.sv
package mnl_pkg;
  localparam int NIBW = 4;

  // 4-bit substitution used by every lane
  function automatic logic [3:0] sbox(input logic [3:0] v);
    case (v)
      4'h0: sbox = 4'h7;  4'h1: sbox = 4'hA;  4'h2: sbox = 4'h2;  4'h3: sbox = 4'hC;
      4'h4: sbox = 4'h4;  4'h5: sbox = 4'h8;  4'h6: sbox = 4'hF;  4'h7: sbox = 4'h0;
      4'h8: sbox = 4'h5;  4'h9: sbox = 4'h9;  4'hA: sbox = 4'h1;  4'hB: sbox = 4'hE;
      4'hC: sbox = 4'h3;  4'hD: sbox = 4'hD;  4'hE: sbox = 4'hB;  default: sbox = 4'h6;
    endcase
  endfunction

  // left-rotation amount applied to state word k before the lookup
  function automatic int rot_amt(input int k);
    case (k)
      1: rot_amt = 1;
      2: rot_amt = 5;
      3: rot_amt = 2;
      default: rot_amt = 0;
    endcase
  endfunction
endpackage

// File: rtl/pad_bank.sv
module pad_bank #(
  parameter int BW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          rld_valid,
  input  logic [BW-1:0] rld_src,
  input  logic [BW-1:0] rld_out,
  output logic [BW-1:0] src_q,
  output logic [BW-1:0] out_q
);
  logic          pend_q;
  logic [BW-1:0] pend_src, pend_out;
  logic          park;     // reload arrives during lookups
  logic          commit;   // pads change at this edge
  logic [BW-1:0] nxt_src, nxt_out;

  assign park    = busy && rld_valid;
  assign commit  = !busy && (rld_valid || pend_q);
  assign nxt_src = rld_valid ? rld_src : pend_src;
  assign nxt_out = rld_valid ? rld_out : pend_out;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      pend_src <= '0;
      pend_out <= '0;
      src_q    <= '0;
      out_q    <= '0;
    end else begin
      if (park) begin
        pend_q   <= 1'b1;
        pend_src <= rld_src;
        pend_out <= rld_out;
      end
      if (commit) begin
        src_q  <= nxt_src;
        out_q  <= nxt_out;
        pend_q <= 1'b0;
      end
    end
  end

  // R9: pads never move while a lookup is in progress
  p_pads_frozen_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(src_q) && $stable(out_q)));
  // R9: a parked reload is consumed by the first idle cycle
  p_pend_drains_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !busy) |=> !pend_q);
  // R10: a reload during lookups leaves a parked set behind
  p_park_latest_r10: assert property (@(posedge clk) disable iff (!rst_n)
    park |=> (pend_q && pend_src == $past(rld_src)));
endmodule

// File: rtl/pad_gather.sv
module pad_gather #(
  parameter int NIB = 32
) (
  input  logic [NIB*mnl_pkg::NIBW-1:0] src_pad,
  output logic [NIB*mnl_pkg::NIBW-1:0] in_pad
);
  localparam int W = mnl_pkg::NIBW;

  for (genvar i = 0; i < NIB; i++) begin : g_lane
    for (genvar k = 0; k < W; k++) begin : g_bit
      localparam int SRCN = (i + NIB - (mnl_pkg::rot_amt(k) % NIB)) % NIB;
      assign in_pad[i*W+k] = src_pad[SRCN*W+k];
    end
  end
endmodule

// File: rtl/nibble_lut.sv
module nibble_lut (
  input  logic [3:0] x,
  input  logic [3:0] cin,
  input  logic [3:0] cout,
  output logic [3:0] y
);
  logic [3:0] tbl [16];

  always_comb begin
    for (int e = 0; e < 16; e++) begin
      tbl[e] = mnl_pkg::sbox(4'(e) ^ cin) ^ cout;
    end
  end

  assign y = tbl[x];
endmodule

// File: rtl/masked_sbox_layer.sv
module masked_sbox_layer #(
  parameter int NIB = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [NIB*mnl_pkg::NIBW-1:0] in_data,
  input  logic                         rld_valid,
  input  logic [NIB*mnl_pkg::NIBW-1:0] rld_src_pad,
  input  logic [NIB*mnl_pkg::NIBW-1:0] rld_out_pad,
  output logic                         out_valid,
  output logic [NIB*mnl_pkg::NIBW-1:0] out_data
);
  localparam int W  = mnl_pkg::NIBW;
  localparam int BW = NIB * W;

  logic          lookup_fire;
  logic [BW-1:0] pad_src, pad_out, pad_in, lut_y;

  assign lookup_fire = in_valid;

  pad_bank #(.BW(BW)) u_bank (
    .clk(clk), .rst_n(rst_n), .busy(lookup_fire),
    .rld_valid(rld_valid), .rld_src(rld_src_pad), .rld_out(rld_out_pad),
    .src_q(pad_src), .out_q(pad_out)
  );

  pad_gather #(.NIB(NIB)) u_gather (.src_pad(pad_src), .in_pad(pad_in));

  for (genvar i = 0; i < NIB; i++) begin : g_lut
    nibble_lut u_lut (
      .x(in_data[i*W +: W]), .cin(pad_in[i*W +: W]),
      .cout(pad_out[i*W +: W]), .y(lut_y[i*W +: W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= lookup_fire;
      if (lookup_fire) out_data <= lut_y;
    end
  end

  // R6: one result per accepted state, one cycle later
  p_valid_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R7: idle cycles leave the result untouched
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));
  // R8: an idle reload is in force on the next cycle
  p_reload_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rld_valid && !in_valid) |=> (pad_src == $past(rld_src_pad) && pad_out == $past(rld_out_pad)));
endmodule

// File: tb/test_masked_sbox_layer.sv
`timescale 1ns/1ps
module test_masked_sbox_layer;
  localparam int NIB = 32;
  localparam int BW  = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, rld_valid = 1'b0;
  logic [BW-1:0] in_data = '0, rld_src_pad = '0, rld_out_pad = '0;
  logic out_valid;
  logic [BW-1:0] out_data;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [BW-1:0] m_src = '0, m_out = '0;   // pads the bench believes active

  always #2 clk = ~clk;

  masked_sbox_layer #(.NIB(NIB)) i_masked_sbox_layer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .rld_valid(rld_valid), .rld_src_pad(rld_src_pad), .rld_out_pad(rld_out_pad),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [3:0] gam(input logic [3:0] v);
    logic [63:0] t = 64'h6BD3E1950F84C2A7;  // entry v sits at nibble v
    return t[v*4 +: 4];
  endfunction

  // mask seen after the word rotations: rotate each mask word left
  function automatic logic [BW-1:0] mask_in(input logic [BW-1:0] src);
    int r[4] = '{0, 1, 5, 2};
    logic [BW-1:0] res = '0;
    for (int k = 0; k < 4; k++) begin
      logic [31:0] w = '0, rw;
      for (int j = 0; j < 32; j++) w[j] = src[j*4+k];
      rw = (r[k] == 0) ? w : ((w << r[k]) | (w >> (32 - r[k])));
      for (int i = 0; i < 32; i++) res[i*4+k] = rw[i];
    end
    return res;
  endfunction

  function automatic logic [BW-1:0] sub_all(input logic [BW-1:0] t);
    logic [BW-1:0] o;
    for (int i = 0; i < NIB; i++) o[i*4 +: 4] = gam(t[i*4 +: 4]);
    return o;
  endfunction

  task automatic chk(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic reload_idle(input logic [BW-1:0] s, input logic [BW-1:0] o);
    @(negedge clk);
    rld_valid = 1; rld_src_pad = s; rld_out_pad = o;
    @(negedge clk);
    rld_valid = 0;
    m_src = s; m_out = o;
  endtask

  // one lookup of a true state; the bench masks it with its pads
  task automatic look(input string req, input logic [BW-1:0] truth);
    @(negedge clk);
    in_valid = 1; in_data = truth ^ mask_in(m_src);
    @(negedge clk);
    in_valid = 0;
    chk(req, {127'd0, out_valid}, 128'd1);
    chk(req, out_data, sub_all(truth) ^ m_out);
  endtask

  task automatic t_reset;
    chk("R1 out_valid", {127'd0, out_valid}, '0);
    chk("R1 out_data", out_data, '0);
    look("R1 zero pads", 128'h0123456789ABCDEF_FEDCBA9876543210);
  endtask

  task automatic t_plain;
    logic [BW-1:0] v;
    for (int i = 0; i < NIB; i++) v[i*4 +: 4] = 4'(i);
    look("R2 R3 all entries", v);
    look("R2 all ones", {BW{1'b1}});
    look("R3 random", {$urandom, $urandom, $urandom, $urandom});
  endtask

  task automatic t_gather;
    logic [BW-1:0] s = '0;
    s[0*4+0] = 1; s[31*4+1] = 1; s[27*4+2] = 1; s[30*4+3] = 1;
    reload_idle(s, '0);
    // lane 0 must see pad F; true state zero
    @(negedge clk);
    in_valid = 1; in_data = 128'h0000000F;
    @(negedge clk);
    in_valid = 0;
    chk("R4 lane0 gather", {124'd0, out_data[3:0]}, {124'd0, gam(4'h0)});
    for (int k = 0; k < 4; k++) begin
      logic [BW-1:0] one = '0;
      one[9*4+k] = 1;
      reload_idle(one, '0);
      look("R4 one-hot source", 128'h5A5A5A5A_C3C3C3C3_0F0F0F0F_96969696);
    end
  endtask

  task automatic t_random_masks;
    for (int n = 0; n < 6; n++) begin
      logic [BW-1:0] t = {$urandom, $urandom, $urandom, $urandom};
      reload_idle({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom});
      look("R5 R8 random pads", t);
      chk("R5 unmask", out_data ^ m_out, sub_all(t));
    end
  endtask

  task automatic t_latency_hold;
    logic [BW-1:0] a = 128'h1, b = 128'h22;
    logic [BW-1:0] keep;
    @(negedge clk);
    in_valid = 1; in_data = a ^ mask_in(m_src);
    chk("R6 not yet", {127'd0, out_valid}, '0);
    @(negedge clk);
    in_data = b ^ mask_in(m_src);
    chk("R6 first", out_data, sub_all(a) ^ m_out);
    @(negedge clk);
    in_valid = 0; in_data = '1;
    chk("R6 second", out_data, sub_all(b) ^ m_out);
    keep = out_data;
    @(negedge clk);
    chk("R6 valid drop", {127'd0, out_valid}, '0);
    repeat (2) @(negedge clk);
    chk("R7 hold", out_data, keep);
  endtask

  task automatic t_reload_burst;
    logic [BW-1:0] ns = {$urandom, $urandom, $urandom, $urandom};
    logic [BW-1:0] no = {$urandom, $urandom, $urandom, $urandom};
    logic [BW-1:0] t1 = 128'hAB, t2 = 128'hCD00, t3 = 128'hEF0000;
    @(negedge clk);
    in_valid = 1; in_data = t1 ^ mask_in(m_src);
    rld_valid = 1; rld_src_pad = ns; rld_out_pad = no;
    @(negedge clk);
    rld_valid = 0; in_data = t2 ^ mask_in(m_src);
    chk("R9 same cycle old pads", out_data, sub_all(t1) ^ m_out);
    @(negedge clk);
    in_valid = 0;
    chk("R9 burst keeps old pads", out_data, sub_all(t2) ^ m_out);
    m_src = ns; m_out = no;
    look("R9 after idle new pads", t3);
  endtask

  task automatic t_latest_wins;
    logic [BW-1:0] s1 = {4{32'h13572468}}, o1 = {4{32'h0F0F0F0F}};
    logic [BW-1:0] s2 = {$urandom, $urandom, $urandom, $urandom};
    logic [BW-1:0] o2 = {$urandom, $urandom, $urandom, $urandom};
    @(negedge clk);
    in_valid = 1; in_data = '0;
    rld_valid = 1; rld_src_pad = s1; rld_out_pad = o1;
    @(negedge clk);
    rld_src_pad = s2; rld_out_pad = o2;
    @(negedge clk);
    rld_valid = 0; in_valid = 0;
    m_src = s2; m_out = o2;
    look("R10 latest set", 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_gather();
    t_random_masks();
    t_latency_hold();
    t_reload_burst();
    t_latest_wins();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule